// File: doc/BRIEF.md
# Immediate-Operand Half-Word ALU

This unit carries out the four short-literal instructions of a 12-bit accumulator machine. Each instruction carries a 6-bit literal in its own word. The unit combines that literal with the current accumulator in one of four ways: mask the low half, toggle bits in the low half, load a sign-extended value, or add a sign-extended value. It returns the new accumulator together with the carry and overflow flags.

The surrounding datapath presents the accumulator, the literal, a 2-bit operation select and the present flag values, and raises `vld_i` for one cycle. The results appear on registered outputs after the next rising clock edge. They hold their value until the next strobe. The flags are sticky. An add can only raise them, and every other operation passes them through unchanged.

In this text, bit 11 is the most significant (sign) bit. The low half is bits 5..0 and the high half is bits 11..6.

Top module: `imm_half_alu`

## Requirements
- R1: While `rst` is high, the next clock edge sets `acc_o` to 0 and clears `cry_o` and `ovf_o`.
- R2: With `op_i`=0 (mask), `acc_o[5:0]` becomes `acc_i[5:0] & lit_i` and `acc_o[11:6]` equals `acc_i[11:6]`.
- R3: With `op_i`=1 (toggle), `acc_o[5:0]` becomes `acc_i[5:0] ^ lit_i` and `acc_o[11:6]` equals `acc_i[11:6]`.
- R4: With `op_i`=2 (load), `acc_o[5:0]` becomes `lit_i` and every bit of `acc_o[11:6]` equals `lit_i[5]`. The value of `acc_i` has no effect.
- R5: With `op_i`=3 (add), `acc_o` becomes `acc_i` plus the literal read as a signed value from -32 to +31, taken modulo 4096.
- R6: On an add, `cry_o` becomes `cry_i` OR the bit that leaves the top of the 12-bit unsigned sum of `acc_i` and the sign-extended literal.
- R7: On an add, `ovf_o` becomes `ovf_i` OR the signed-overflow condition. That condition holds when the true signed sum lies outside -2048..+2047, which is the same as a carry into bit 11 that differs from the carry out of it.
- R8: For mask, toggle and load, `cry_o` equals `cry_i` and `ovf_o` equals `ovf_i`.
- R9: While `vld_i` is low, `acc_o`, `cry_o` and `ovf_o` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Execute strobe |
| op_i | input | 2 | Operation: 0 mask, 1 toggle, 2 load, 3 add |
| acc_i | input | 12 | Current accumulator |
| lit_i | input | 6 | Literal field of the instruction |
| cry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| acc_o | output | 12 | New accumulator (registered) |
| cry_o | output | 1 | New carry flag (registered) |
| ovf_o | output | 1 | New overflow flag (registered) |

## Verification
Carry-out and signed overflow can both arise from a single add. The bench provokes this by adding -1 to 0x800, which must give 0x7FF with both flags raised, and also by adding +1 to 0xFFF, which must give a carry without overflow. A behavioural reference computes the carry from an unsigned integer sum and the overflow from a signed integer range test. The bench compares both flags against that reference on every clock, including the cycles where incoming sticky flags are already set, so the two causes are judged separately.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  typedef enum logic [1:0] {
    LOP_AND  = 2'd0,
    LOP_XOR  = 2'd1,
    LOP_LOAD = 2'd2,
    LOP_ADD  = 2'd3
  } lop_e;
endpackage

// File: rtl/imm_sext.sv
module imm_sext #(
  parameter int LIT_W  = 6,
  parameter int DATA_W = 12
) (
  input  logic [LIT_W-1:0]  lit_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int HI_W = DATA_W - LIT_W;

  // Replicate the literal's top bit into every upper position.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < LIT_W) begin : g_low
      assign ext_o[i] = lit_i[i];
    end else begin : g_high
      assign ext_o[i] = lit_i[LIT_W-1];
    end
  end

  initial begin
    if (HI_W < 0) $error("literal wider than data path");
  end
endmodule

// File: rtl/imm_half_logic.sv
module imm_half_logic #(
  parameter int DATA_W = 12,
  parameter int LIT_W  = 6
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic              use_xor_i,
  output logic [DATA_W-1:0] res_o
);
  // Low half is combined bitwise with the literal; the high half passes through.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < LIT_W) begin : g_op
      assign res_o[i] = use_xor_i ? (acc_i[i] ^ lit_i[i]) : (acc_i[i] & lit_i[i]);
    end else begin : g_keep
      assign res_o[i] = acc_i[i];
    end
  end
endmodule

// File: rtl/imm_ripple_add.sv
module imm_ripple_add #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  logic [DATA_W:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[DATA_W];
  // Sign is wrong when the carry into the top bit disagrees with the carry out.
  assign ovf_o  = c[DATA_W] ^ c[DATA_W-1];
endmodule

// File: rtl/imm_half_alu.sv
module imm_half_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LIT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic              cry_i,
  input  logic              ovf_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              cry_o,
  output logic              ovf_o
);
  lop_e              op;
  logic [DATA_W-1:0] lit_ext;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic              add_ovf;
  logic [DATA_W-1:0] acc_nxt;
  logic              cry_nxt;
  logic              ovf_nxt;

  assign op = lop_e'(op_i);

  imm_sext #(.LIT_W(LIT_W), .DATA_W(DATA_W)) u_sext (
    .lit_i (lit_i),
    .ext_o (lit_ext)
  );

  imm_half_logic #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_logic (
    .acc_i     (acc_i),
    .lit_i     (lit_i),
    .use_xor_i (op == LOP_XOR),
    .res_o     (logic_res)
  );

  imm_ripple_add #(.DATA_W(DATA_W)) u_add (
    .a_i    (acc_i),
    .b_i    (lit_ext),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  always_comb begin
    acc_nxt = logic_res;
    cry_nxt = cry_i;
    ovf_nxt = ovf_i;
    unique case (op)
      LOP_AND, LOP_XOR: acc_nxt = logic_res;
      LOP_LOAD:         acc_nxt = lit_ext;
      LOP_ADD: begin
        acc_nxt = add_sum;
        cry_nxt = cry_i | add_cout;
        ovf_nxt = ovf_i | add_ovf;
      end
      default:          acc_nxt = logic_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      cry_o <= 1'b0;
      ovf_o <= 1'b0;
    end else if (vld_i) begin
      acc_o <= acc_nxt;
      cry_o <= cry_nxt;
      ovf_o <= ovf_nxt;
    end
  end
endmodule

// File: rtl/imm_half_alu_chk.sv
module imm_half_alu_chk #(
  parameter int DATA_W = 12,
  parameter int LIT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              vld_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [LIT_W-1:0]  lit_i,
  input logic              cry_i,
  input logic              ovf_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              cry_o,
  input logic              ovf_o
);
  localparam int HI_W = DATA_W - LIT_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !cry_o && !ovf_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(acc_o) && $stable(cry_o) && $stable(ovf_o)));

  // R2
  mask_high_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd0) |=> acc_o[DATA_W-1:LIT_W] == $past(acc_i[DATA_W-1:LIT_W]));

  // R3
  toggle_high_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd1) |=> acc_o[DATA_W-1:LIT_W] == $past(acc_i[DATA_W-1:LIT_W]));

  // R4
  load_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd2) |=> acc_o == {{HI_W{$past(lit_i[LIT_W-1])}}, $past(lit_i)});

  // R8
  flag_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i != 2'd3) |=> (cry_o == $past(cry_i) && ovf_o == $past(ovf_i)));

  // R6
  carry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && cry_i) |=> cry_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd3 && !ovf_i && (acc_i[DATA_W-1] != lit_i[LIT_W-1])) |=> !ovf_o);
endmodule

bind imm_half_alu imm_half_alu_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .vld_i (vld_i),
  .op_i  (op_i),
  .acc_i (acc_i),
  .lit_i (lit_i),
  .cry_i (cry_i),
  .ovf_i (ovf_i),
  .acc_o (acc_o),
  .cry_o (cry_o),
  .ovf_o (ovf_o)
);

// File: tb/sim_imm_half_alu.sv
`timescale 1ns/1ps
module sim_imm_half_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [11:0] acc_i = '0;
  logic [5:0]  lit_i = '0;
  logic        cry_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic [11:0] acc_o;
  logic        cry_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;

  // Reference state
  int exp_acc = 0;
  int exp_c = 0;
  int exp_v = 0;

  always #2 clk = ~clk;

  imm_half_alu u0 (
    .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i), .acc_i(acc_i),
    .lit_i(lit_i), .cry_i(cry_i), .ovf_i(ovf_i),
    .acc_o(acc_o), .cry_o(cry_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural model of one strobed operation.
  task automatic model(input int op, input int a, input int y, input int c, input int v);
    int ys;
    int sa;
    int ssum;
    int usum;
    ys = (y >= 32) ? y - 64 : y;
    case (op)
      0: begin exp_acc = (a / 64) * 64 + ((a % 64) & y); exp_c = c; exp_v = v; end
      1: begin exp_acc = (a / 64) * 64 + ((a % 64) ^ y); exp_c = c; exp_v = v; end
      2: begin exp_acc = (ys + 4096) % 4096; exp_c = c; exp_v = v; end
      default: begin
        usum = a + ((ys + 4096) % 4096);
        sa = (a >= 2048) ? a - 4096 : a;
        ssum = sa + ys;
        exp_acc = usum % 4096;
        exp_c = c | ((usum >= 4096) ? 1 : 0);
        exp_v = v | ((ssum > 2047 || ssum < -2048) ? 1 : 0);
      end
    endcase
  endtask

  task automatic step(input bit v, input int op, input int a, input int y,
                      input int c, input int o);
    string tag;
    @(negedge clk);
    vld_i = v; op_i = op[1:0]; acc_i = a[11:0]; lit_i = y[5:0];
    cry_i = c[0]; ovf_i = o[0];
    if (v) model(op, a, y, c, o);
    @(posedge clk);
    #1;
    if (!v) begin
      check("R9 acc hold", acc_o, exp_acc);
      check("R9 carry hold", cry_o, exp_c);
      check("R9 ovf hold", ovf_o, exp_v);
    end else begin
      case (op)
        0: tag = "R2 mask";
        1: tag = "R3 toggle";
        2: tag = "R4 load";
        default: tag = "R5 add";
      endcase
      check(tag, acc_o, exp_acc);
      check(op == 3 ? "R6 carry" : "R8 carry pass", cry_o, exp_c);
      check(op == 3 ? "R7 overflow" : "R8 ovf pass", ovf_o, exp_v);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset acc", acc_o, 0);
    check("R1 reset carry", cry_o, 0);
    check("R1 reset ovf", ovf_o, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3: high half kept
    step(1, 0, 'hA5C, 'h0F, 0, 0);
    step(1, 1, 'h3F0, 'h3F, 1, 0);
    step(1, 0, 'hFFF, 'h00, 0, 1);
    // R4: sign fill and acc ignored
    step(1, 2, 'h123, 'h20, 0, 0);
    step(1, 2, 'hFFF, 'h1F, 1, 1);
    // R5 / R6 / R7 corners
    step(1, 3, 'h7FF, 'h01, 0, 0);  // ovf only
    step(1, 3, 'h800, 'h3F, 0, 0);  // carry and ovf together
    step(1, 3, 'hFFF, 'h01, 0, 0);  // carry only
    step(1, 3, 'h800, 'h20, 0, 0);  // -2048 + -32
    step(1, 3, 'h000, 'h01, 1, 1);  // sticky flags
    step(1, 3, 'h010, 'h3E, 0, 0);  // 16 - 2
    // R9: idle with changing inputs
    step(0, 2, 'h555, 'h2A, 1, 1);
    step(0, 3, 'hFFF, 'h3F, 1, 1);

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 7);
      step(r != 0, $urandom_range(0, 3),
           (r == 7) ? (($urandom_range(0, 1) != 0) ? 'h7FF : 'h800) : $urandom_range(0, 4095),
           $urandom_range(0, 63), $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule